// File: doc/BRIEF.md
# Wrong-Path Hint Detector

This block sits beside the execution stage of an out-of-order core and watches the reports that several units send each cycle. It looks for instructions that behave illegally or in an unusual way. Such behaviour almost always means that the instruction was fetched down a mispredicted branch. Examples are a data access through address zero, a divide by zero, or an empty return stack being popped. For each such case the block raises a speculative hint without waiting for retirement. A recovery unit can then start repairing the mispredicted branch before that branch resolves.

The reporting units are the data-memory port, the TLB miss tracker, the branch resolution port, the return stack, the fetch unit and the divider. Each report is tagged with the instruction's sequence number and PC. The data segment bounds, the code region bounds and the read-only flag of the accessed page arrive as inputs. If several reports trigger in the same cycle, only the oldest one is passed on, as a registered pulse that carries its sequence number, its PC and a 4-bit cause code. Handling the exceptions themselves, walking page tables and flushing the pipeline are left to other blocks.

Top module: `wrongpath_detect`

## Requirements
- R1: A valid load or store whose address is zero produces cause code 1.
- R2: A valid store to a page flagged read-only produces cause code 2. A load from such a page produces no hint.
- R3: A valid access whose address is not a multiple of its size produces cause code 3. The size field holds log2 of the byte count (0=1, 1=2, 2=4, 3=8). Byte accesses are never misaligned.
- R4: A valid access below the segment low bound or above the segment high bound produces code 4. Both bounds are inclusive. An access inside the code region (both bounds inclusive) produces code 5. Within one access the precedence is 1, then 2, then 3, then 4, then 5.
- R5: The block counts TLB misses that are outstanding. A new miss that brings this count to TLB_LIMIT (default 3) or above produces code 6, tagged with that miss's sequence number and PC.
- R6: A branch that resolves as mispredicted while older branches are still unresolved adds one to a nesting counter. When the counter reaches MISP_LIMIT (default 3), the block produces code 7, tagged with that branch, and the counter returns to zero. A mispredict with no older unresolved branch is not counted.
- R7: When the oldest unresolved branch resolves, or on a flush, the nesting counter clears. A mispredict reported in the same cycle is not counted.
- R8: A return-stack pop while the stack is empty produces code 8. A pop from a stack that is not empty produces no hint.
- R9: A valid fetch whose address is not a multiple of INSN_BYTES (default 4) produces code 9.
- R10: A valid divide whose divisor is zero produces code 10.
- R11: If several sources trigger in one cycle, the oldest sequence number wins. Age is judged by wrapping difference: a is older than b when (a-b) has its top bit set. On equal sequence numbers the order is memory, TLB, nesting, return stack, fetch, divide.
- R12: Each hint appears on the outputs one clock after its trigger and lasts one cycle. With no trigger, hint_valid, hint_code and hint_seq are zero. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_lo | input | AW | Lowest valid data address |
| seg_hi | input | AW | Highest valid data address |
| code_lo | input | AW | Lowest code-region address |
| code_hi | input | AW | Highest code-region address |
| mem_valid | input | 1 | Data access report |
| mem_is_store | input | 1 | Access is a store |
| mem_size | input | 2 | log2 of the access size in bytes |
| mem_addr | input | AW | Effective address |
| mem_page_ro | input | 1 | Accessed page is read-only |
| mem_seq | input | SW | Sequence number of the access |
| mem_pc | input | PW | PC of the access |
| tlb_miss_new | input | 1 | A new TLB miss begins |
| tlb_miss_done | input | 1 | An outstanding TLB miss completes |
| tlb_miss_seq | input | SW | Sequence number of the new miss |
| tlb_miss_pc | input | PW | PC of the new miss |
| br_valid | input | 1 | A branch resolves |
| br_mispred | input | 1 | The resolving branch was mispredicted |
| br_older_open | input | 1 | Older unresolved branches exist |
| br_oldest_done | input | 1 | The oldest unresolved branch resolves |
| br_seq | input | SW | Sequence number of the resolving branch |
| br_pc | input | PW | PC of the resolving branch |
| flush | input | 1 | Pipeline flush |
| ret_stack_pop | input | 1 | Return stack pop |
| ret_stack_empty | input | 1 | Return stack is empty |
| ret_seq | input | SW | Sequence number of the popping return |
| ret_pc | input | PW | PC of the popping return |
| fetch_valid | input | 1 | Fetch report |
| fetch_addr | input | PW | Fetch address |
| fetch_seq | input | SW | Sequence number of the fetched instruction |
| div_valid | input | 1 | Divide report |
| div_divisor | input | DW | Divisor operand |
| div_seq | input | SW | Sequence number of the divide |
| div_pc | input | PW | PC of the divide |
| hint_valid | output | 1 | Wrong-path hint pulse |
| hint_code | output | 4 | Cause code |
| hint_seq | output | SW | Sequence number of the reported instruction |
| hint_pc | output | PW | PC of the reported instruction |

## Verification
Every hint is due exactly one clock after the cycle in which its trigger is driven. This holds for single-cycle triggers and for the counter-based causes, because both counters decide from their stored value together with the current input. The bench drives inputs on the falling edge, and the next falling edge comes after one rising edge. It checks the outputs on that second falling edge and only then returns the inputs to idle. The checks on the two counters walk them one cycle at a time and look for silence on every cycle before the one that triggers.

// File: rtl/wrongpath_pkg.sv
package wrongpath_pkg;

   typedef enum logic [3:0] {
      HC_NONE           = 4'd0,
      HC_NULL_PTR       = 4'd1,
      HC_RO_WRITE       = 4'd2,
      HC_DATA_MISALIGN  = 4'd3,
      HC_OUT_OF_SEG     = 4'd4,
      HC_CODE_TOUCH     = 4'd5,
      HC_TLB_PILEUP     = 4'd6,
      HC_MISP_NEST      = 4'd7,
      HC_RET_UNDERFLOW  = 4'd8,
      HC_FETCH_MISALIGN = 4'd9,
      HC_DIV_ZERO       = 4'd10
   } hint_code_e;

   // source slots; index order is the tie-break order
   localparam int SRC_MEM   = 0;
   localparam int SRC_TLB   = 1;
   localparam int SRC_NEST  = 2;
   localparam int SRC_RET   = 3;
   localparam int SRC_FETCH = 4;
   localparam int SRC_DIV   = 5;
   localparam int NUM_SRC   = 6;

endpackage

// File: rtl/wrongpath_mem_check.sv
module wrongpath_mem_check
   import wrongpath_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          valid,
   input  logic          is_store,
   input  logic [1:0]    size,
   input  logic [AW-1:0] addr,
   input  logic          page_ro,
   input  logic [AW-1:0] seg_lo,
   input  logic [AW-1:0] seg_hi,
   input  logic [AW-1:0] code_lo,
   input  logic [AW-1:0] code_hi,
   output logic          hit,
   output hint_code_e    code
);

   initial assert (AW >= 4) else $fatal(1, "AW must be at least 4");

   logic [AW-1:0] align_mask;
   logic          is_null, ro_bad, misalign, out_seg, in_code;

   always_comb begin
      align_mask = (AW'(1) << size) - AW'(1);
      is_null    = (addr == '0);
      ro_bad     = is_store && page_ro;
      misalign   = |(addr & align_mask);
      out_seg    = (addr < seg_lo) || (addr > seg_hi);
      in_code    = (addr >= code_lo) && (addr <= code_hi);
   end

   always_comb begin
      hit  = 1'b0;
      code = HC_NONE;
      if (valid) begin
         hit = 1'b1;
         if (is_null)       code = HC_NULL_PTR;
         else if (ro_bad)   code = HC_RO_WRITE;
         else if (misalign) code = HC_DATA_MISALIGN;
         else if (out_seg)  code = HC_OUT_OF_SEG;
         else if (in_code)  code = HC_CODE_TOUCH;
         else               hit  = 1'b0;
      end
   end

   // R4: a null access never reports a lower-precedence cause
   always_comb begin
      if (valid && is_null)
         p_null_first_r4: assert (code == HC_NULL_PTR);
   end

endmodule

// File: rtl/wrongpath_ctrl_track.sv
module wrongpath_ctrl_track #(
   parameter int MISP_LIMIT = 3,
   parameter int TLB_LIMIT  = 3,
   parameter int TLB_MAX    = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic br_valid,
   input  logic br_mispred,
   input  logic br_older_open,
   input  logic br_oldest_done,
   input  logic flush,
   input  logic tlb_new,
   input  logic tlb_done,
   output logic nest_hit,
   output logic tlb_hit
);

   localparam int MW = (MISP_LIMIT < 2) ? 1 : $clog2(MISP_LIMIT);
   localparam int TW = $clog2(TLB_MAX + 1);

   initial assert (MISP_LIMIT >= 1) else $fatal(1, "MISP_LIMIT must be >= 1");
   initial assert (TLB_LIMIT >= 1 && TLB_LIMIT <= TLB_MAX)
      else $fatal(1, "TLB_LIMIT must lie in 1..TLB_MAX");

   // nesting counter
   logic          counting, clr;
   logic [MW-1:0] nest_cnt, nest_nxt;

   assign counting = br_valid && br_mispred && br_older_open;
   assign clr      = flush || br_oldest_done;

   generate
      if (MISP_LIMIT == 1) begin : g_nest_single
         assign nest_hit = counting && !clr;
         assign nest_nxt = '0;
      end else begin : g_nest_count
         always_comb begin
            nest_hit = counting && !clr && (nest_cnt == MW'(MISP_LIMIT - 1));
            if (clr || nest_hit) nest_nxt = '0;
            else if (counting)   nest_nxt = nest_cnt + MW'(1);
            else                 nest_nxt = nest_cnt;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) nest_cnt <= '0;
      else        nest_cnt <= nest_nxt;
   end

   // outstanding TLB miss counter
   logic [TW-1:0] tlb_cnt, tlb_nxt;

   always_comb begin
      tlb_nxt = tlb_cnt;
      if (tlb_new && !tlb_done)
         tlb_nxt = (tlb_cnt == TW'(TLB_MAX)) ? tlb_cnt : tlb_cnt + TW'(1);
      else if (!tlb_new && tlb_done)
         tlb_nxt = (tlb_cnt == '0) ? tlb_cnt : tlb_cnt - TW'(1);
      tlb_hit = tlb_new && (int'(tlb_nxt) >= TLB_LIMIT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tlb_cnt <= '0;
      else        tlb_cnt <= tlb_nxt;
   end

   p_nest_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (nest_cnt == '0));

   p_nest_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      nest_hit |=> (nest_cnt == '0));

   p_nest_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(nest_cnt) < ((MISP_LIMIT < 2) ? 1 : MISP_LIMIT));

   p_tlb_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(tlb_cnt) <= TLB_MAX);

endmodule

// File: rtl/wrongpath_oldest_pick.sv
module wrongpath_oldest_pick
   import wrongpath_pkg::*;
#(
   parameter int N  = 6,
   parameter int SW = 8,
   parameter int PW = 32
) (
   input  logic [N-1:0]          req,
   input  logic [N-1:0][SW-1:0]  seq,
   input  logic [N-1:0][PW-1:0]  pc,
   input  hint_code_e            code [N],
   output logic                  any,
   output logic [SW-1:0]         win_seq,
   output logic [PW-1:0]         win_pc,
   output hint_code_e            win_code,
   output logic [N-1:0]          grant
);

   initial assert (N >= 2 && SW >= 2) else $fatal(1, "bad arbiter sizing");

   function automatic logic older(input logic [SW-1:0] a, input logic [SW-1:0] b);
      logic [SW-1:0] d;
      d = a - b;
      return d[SW-1];
   endfunction

   always_comb begin
      any      = 1'b0;
      win_seq  = '0;
      win_pc   = '0;
      win_code = HC_NONE;
      grant    = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (!any || older(seq[i], win_seq))) begin
            any      = 1'b1;
            win_seq  = seq[i];
            win_pc   = pc[i];
            win_code = code[i];
            grant    = '0;
            grant[i] = 1'b1;
         end
      end
   end

   // R11: exactly one winner whenever any source asks
   always_comb begin
      p_grant_onehot_r11: assert ($onehot0(grant) && ((|grant) == (|req)));
   end

endmodule

// File: rtl/wrongpath_detect.sv
module wrongpath_detect
   import wrongpath_pkg::*;
#(
   parameter int AW         = 32,
   parameter int SW         = 8,
   parameter int PW         = 32,
   parameter int DW         = 32,
   parameter int INSN_BYTES = 4,
   parameter int MISP_LIMIT = 3,
   parameter int TLB_LIMIT  = 3,
   parameter int TLB_MAX    = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] seg_lo,
   input  logic [AW-1:0] seg_hi,
   input  logic [AW-1:0] code_lo,
   input  logic [AW-1:0] code_hi,
   input  logic          mem_valid,
   input  logic          mem_is_store,
   input  logic [1:0]    mem_size,
   input  logic [AW-1:0] mem_addr,
   input  logic          mem_page_ro,
   input  logic [SW-1:0] mem_seq,
   input  logic [PW-1:0] mem_pc,
   input  logic          tlb_miss_new,
   input  logic          tlb_miss_done,
   input  logic [SW-1:0] tlb_miss_seq,
   input  logic [PW-1:0] tlb_miss_pc,
   input  logic          br_valid,
   input  logic          br_mispred,
   input  logic          br_older_open,
   input  logic          br_oldest_done,
   input  logic [SW-1:0] br_seq,
   input  logic [PW-1:0] br_pc,
   input  logic          flush,
   input  logic          ret_stack_pop,
   input  logic          ret_stack_empty,
   input  logic [SW-1:0] ret_seq,
   input  logic [PW-1:0] ret_pc,
   input  logic          fetch_valid,
   input  logic [PW-1:0] fetch_addr,
   input  logic [SW-1:0] fetch_seq,
   input  logic          div_valid,
   input  logic [DW-1:0] div_divisor,
   input  logic [SW-1:0] div_seq,
   input  logic [PW-1:0] div_pc,
   output logic          hint_valid,
   output logic [3:0]    hint_code,
   output logic [SW-1:0] hint_seq,
   output logic [PW-1:0] hint_pc
);

   initial assert (INSN_BYTES >= 1 && (INSN_BYTES & (INSN_BYTES - 1)) == 0)
      else $fatal(1, "INSN_BYTES must be a power of two");
   initial assert (DW >= 1 && PW >= 2) else $fatal(1, "bad widths");

   // memory checks
   logic       mem_hit;
   hint_code_e mem_code;

   wrongpath_mem_check #(.AW(AW)) u_mem (
      .valid    (mem_valid),
      .is_store (mem_is_store),
      .size     (mem_size),
      .addr     (mem_addr),
      .page_ro  (mem_page_ro),
      .seg_lo   (seg_lo),
      .seg_hi   (seg_hi),
      .code_lo  (code_lo),
      .code_hi  (code_hi),
      .hit      (mem_hit),
      .code     (mem_code)
   );

   // counter-based causes
   logic nest_hit, tlb_hit;

   wrongpath_ctrl_track #(
      .MISP_LIMIT (MISP_LIMIT),
      .TLB_LIMIT  (TLB_LIMIT),
      .TLB_MAX    (TLB_MAX)
   ) u_track (
      .clk            (clk),
      .rst_n          (rst_n),
      .br_valid       (br_valid),
      .br_mispred     (br_mispred),
      .br_older_open  (br_older_open),
      .br_oldest_done (br_oldest_done),
      .flush          (flush),
      .tlb_new        (tlb_miss_new),
      .tlb_done       (tlb_miss_done),
      .nest_hit       (nest_hit),
      .tlb_hit        (tlb_hit)
   );

   // fetch alignment
   logic fetch_bad;
   generate
      if (INSN_BYTES == 1) begin : g_fetch_byte
         assign fetch_bad = 1'b0;
      end else begin : g_fetch_word
         localparam int LB = $clog2(INSN_BYTES);
         assign fetch_bad = fetch_valid && (|fetch_addr[LB-1:0]);
      end
   endgenerate

   logic ret_bad, div_bad;
   assign ret_bad = ret_stack_pop && ret_stack_empty;
   assign div_bad = div_valid && (div_divisor == '0);

   // gather sources
   logic [NUM_SRC-1:0]          src_req;
   logic [NUM_SRC-1:0][SW-1:0]  src_seq;
   logic [NUM_SRC-1:0][PW-1:0]  src_pc;
   hint_code_e                  src_code [NUM_SRC];

   always_comb begin
      src_req[SRC_MEM]    = mem_hit;
      src_seq[SRC_MEM]    = mem_seq;
      src_pc[SRC_MEM]     = mem_pc;
      src_code[SRC_MEM]   = mem_code;
      src_req[SRC_TLB]    = tlb_hit;
      src_seq[SRC_TLB]    = tlb_miss_seq;
      src_pc[SRC_TLB]     = tlb_miss_pc;
      src_code[SRC_TLB]   = HC_TLB_PILEUP;
      src_req[SRC_NEST]   = nest_hit;
      src_seq[SRC_NEST]   = br_seq;
      src_pc[SRC_NEST]    = br_pc;
      src_code[SRC_NEST]  = HC_MISP_NEST;
      src_req[SRC_RET]    = ret_bad;
      src_seq[SRC_RET]    = ret_seq;
      src_pc[SRC_RET]     = ret_pc;
      src_code[SRC_RET]   = HC_RET_UNDERFLOW;
      src_req[SRC_FETCH]  = fetch_bad;
      src_seq[SRC_FETCH]  = fetch_seq;
      src_pc[SRC_FETCH]   = fetch_addr;
      src_code[SRC_FETCH] = HC_FETCH_MISALIGN;
      src_req[SRC_DIV]    = div_bad;
      src_seq[SRC_DIV]    = div_seq;
      src_pc[SRC_DIV]     = div_pc;
      src_code[SRC_DIV]   = HC_DIV_ZERO;
   end

   logic               win_any;
   logic [SW-1:0]      win_seq;
   logic [PW-1:0]      win_pc;
   hint_code_e         win_code;
   logic [NUM_SRC-1:0] win_grant;

   wrongpath_oldest_pick #(.N(NUM_SRC), .SW(SW), .PW(PW)) u_pick (
      .req      (src_req),
      .seq      (src_seq),
      .pc       (src_pc),
      .code     (src_code),
      .any      (win_any),
      .win_seq  (win_seq),
      .win_pc   (win_pc),
      .win_code (win_code),
      .grant    (win_grant)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hint_valid <= 1'b0;
         hint_code  <= '0;
         hint_seq   <= '0;
         hint_pc    <= '0;
      end else begin
         hint_valid <= win_any;
         hint_code  <= win_code;
         hint_seq   <= win_seq;
         hint_pc    <= win_pc;
      end
   end

   p_null_hint_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_addr == '0) |=> hint_valid);

   p_div_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (div_valid && div_divisor == '0) |=> hint_valid);

   p_ret_under_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_stack_pop && ret_stack_empty) |=> hint_valid);

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_valid && !tlb_miss_new && !(br_valid && br_mispred) &&
       !ret_stack_pop && !fetch_valid && !div_valid) |=> !hint_valid);

   p_code_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
      hint_valid |-> (hint_code != 4'd0));

endmodule

// File: tb/wrongpath_detect_bench.sv
module wrongpath_detect_bench;

   localparam int AW = 32, SW = 8, PW = 32, DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] seg_lo, seg_hi, code_lo, code_hi;
   logic          mem_valid, mem_is_store, mem_page_ro;
   logic [1:0]    mem_size;
   logic [AW-1:0] mem_addr;
   logic [SW-1:0] mem_seq;
   logic [PW-1:0] mem_pc;
   logic          tlb_miss_new, tlb_miss_done;
   logic [SW-1:0] tlb_miss_seq;
   logic [PW-1:0] tlb_miss_pc;
   logic          br_valid, br_mispred, br_older_open, br_oldest_done, flush;
   logic [SW-1:0] br_seq;
   logic [PW-1:0] br_pc;
   logic          ret_stack_pop, ret_stack_empty;
   logic [SW-1:0] ret_seq;
   logic [PW-1:0] ret_pc;
   logic          fetch_valid;
   logic [PW-1:0] fetch_addr;
   logic [SW-1:0] fetch_seq;
   logic          div_valid;
   logic [DW-1:0] div_divisor;
   logic [SW-1:0] div_seq;
   logic [PW-1:0] div_pc;
   logic          hint_valid;
   logic [3:0]    hint_code;
   logic [SW-1:0] hint_seq;
   logic [PW-1:0] hint_pc;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   wrongpath_detect u_wrongpath_detect (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic expect_hint(input string req, input logic v, input int code, input int seq);
      chk({req, " valid"}, 64'(hint_valid), 64'(v));
      if (v) begin
         chk({req, " code"}, 64'(hint_code), 64'(code));
         chk({req, " seq"},  64'(hint_seq),  64'(seq));
      end
   endtask

   task automatic idle();
      mem_valid = 0; mem_is_store = 0; mem_page_ro = 0; mem_size = 0;
      mem_addr = 32'h4000; mem_seq = 0; mem_pc = 0;
      tlb_miss_new = 0; tlb_miss_done = 0; tlb_miss_seq = 0; tlb_miss_pc = 0;
      br_valid = 0; br_mispred = 0; br_older_open = 0; br_oldest_done = 0;
      flush = 0; br_seq = 0; br_pc = 0;
      ret_stack_pop = 0; ret_stack_empty = 0; ret_seq = 0; ret_pc = 0;
      fetch_valid = 0; fetch_addr = 0; fetch_seq = 0;
      div_valid = 0; div_divisor = 1; div_seq = 0; div_pc = 0;
   endtask

   // inputs already driven on a falling edge; wait for the next one
   task automatic step();
      @(negedge clk);
   endtask

   task automatic mem_op(input logic st, input logic ro, input logic [1:0] sz,
                         input logic [AW-1:0] a, input int sq);
      mem_valid = 1; mem_is_store = st; mem_page_ro = ro; mem_size = sz;
      mem_addr = a; mem_seq = SW'(sq); mem_pc = 32'h100 + 32'(sq);
   endtask

   task automatic t_reset();
      chk("R12 reset valid", 64'(hint_valid), 0);
      chk("R12 reset code",  64'(hint_code), 0);
   endtask

   task automatic t_null();
      mem_op(1, 0, 2, 32'h0, 5); step();
      expect_hint("R1 null", 1, 1, 5);
      chk("R1 pc", 64'(hint_pc), 64'(32'h105));
      idle(); step();
      expect_hint("R12 pulse ends", 0, 0, 0);
   endtask

   task automatic t_readonly();
      mem_op(1, 1, 2, 32'h4000, 7); step();
      expect_hint("R2 ro store", 1, 2, 7); idle();
      mem_op(0, 1, 2, 32'h4000, 8); step();
      expect_hint("R2 ro load ignored", 0, 0, 0); idle();
   endtask

   task automatic t_align();
      mem_op(0, 0, 2, 32'h4002, 9); step();
      expect_hint("R3 word misaligned", 1, 3, 9); idle();
      mem_op(0, 0, 0, 32'h4003, 10); step();
      expect_hint("R3 byte never misaligned", 0, 0, 0); idle();
      mem_op(1, 1, 3, 32'h4004, 11); step();
      expect_hint("R4 ro beats misalign", 1, 2, 11); idle();
   endtask

   task automatic t_segment();
      mem_op(0, 0, 2, 32'h10000, 12); step();
      expect_hint("R4 above seg", 1, 4, 12); idle();
      mem_op(0, 0, 2, 32'h0800, 13); step();
      expect_hint("R4 below seg", 1, 4, 13); idle();
      mem_op(0, 0, 2, 32'hFFFC, 14); step();
      expect_hint("R4 top edge inside", 0, 0, 0); idle();
      mem_op(0, 0, 2, 32'h1800, 15); step();
      expect_hint("R4 code region", 1, 5, 15); idle();
   endtask

   task automatic t_tlb();
      for (int k = 0; k < 3; k++) begin
         tlb_miss_new = 1; tlb_miss_seq = SW'(20 + k); tlb_miss_pc = 32'h200;
         step();
         if (k < 2) expect_hint("R5 below limit", 0, 0, 0);
         else       expect_hint("R5 limit reached", 1, 6, 22);
         idle();
      end
      for (int k = 0; k < 3; k++) begin
         tlb_miss_done = 1; step(); idle();
      end
      tlb_miss_new = 1; tlb_miss_seq = 8'd30; step();
      expect_hint("R5 drained no hint", 0, 0, 0); idle();
      tlb_miss_done = 1; step(); idle();
   endtask

   task automatic misp(input logic older, input int sq);
      br_valid = 1; br_mispred = 1; br_older_open = older;
      br_seq = SW'(sq); br_pc = 32'h300 + 32'(sq);
   endtask

   task automatic t_nest();
      for (int k = 0; k < 3; k++) begin
         misp(0, 40 + k); step();
         expect_hint("R6 no older ignored", 0, 0, 0); idle();
      end
      for (int k = 0; k < 3; k++) begin
         misp(1, 50 + k); step();
         if (k < 2) expect_hint("R6 counting", 0, 0, 0);
         else       expect_hint("R6 third nested", 1, 7, 52);
         idle();
      end
      // after the hint the count restarts
      misp(1, 60); step(); idle();
      misp(1, 61); step(); idle();
      flush = 1; step(); idle();
      misp(1, 62); step(); idle();
      misp(1, 63); step();
      expect_hint("R7 flush cleared", 0, 0, 0); idle();
      // count is now two; clear with a same-cycle mispredict
      misp(1, 64); br_oldest_done = 1; step();
      expect_hint("R7 clear wins", 0, 0, 0); idle();
      misp(1, 65); step(); idle();
      misp(1, 66); step();
      expect_hint("R7 still counting", 0, 0, 0); idle();
      misp(1, 67); step();
      expect_hint("R7 refill to limit", 1, 7, 67); idle();
   endtask

   task automatic t_ret();
      ret_stack_pop = 1; ret_stack_empty = 1; ret_seq = 8'd70; step();
      expect_hint("R8 underflow", 1, 8, 70); idle();
      ret_stack_pop = 1; ret_stack_empty = 0; ret_seq = 8'd71; step();
      expect_hint("R8 normal pop", 0, 0, 0); idle();
   endtask

   task automatic t_fetch();
      fetch_valid = 1; fetch_addr = 32'h4002; fetch_seq = 8'd72; step();
      expect_hint("R9 misaligned fetch", 1, 9, 72);
      chk("R9 pc", 64'(hint_pc), 64'(32'h4002)); idle();
      fetch_valid = 1; fetch_addr = 32'h4004; fetch_seq = 8'd73; step();
      expect_hint("R9 aligned fetch", 0, 0, 0); idle();
   endtask

   task automatic t_div();
      div_valid = 1; div_divisor = 0; div_seq = 8'd74; div_pc = 32'h500; step();
      expect_hint("R10 divide by zero", 1, 10, 74); idle();
      div_valid = 1; div_divisor = 7; div_seq = 8'd75; step();
      expect_hint("R10 nonzero divisor", 0, 0, 0); idle();
   endtask

   task automatic t_oldest();
      mem_op(0, 0, 2, 32'h0, 20);
      div_valid = 1; div_divisor = 0; div_seq = 8'd10; step();
      expect_hint("R11 older divide wins", 1, 10, 10); idle();
      mem_op(0, 0, 2, 32'h0, 3);
      fetch_valid = 1; fetch_addr = 32'h4001; fetch_seq = 8'd250; step();
      expect_hint("R11 wrapped age", 1, 9, 250); idle();
      mem_op(0, 0, 2, 32'h0, 40);
      div_valid = 1; div_divisor = 0; div_seq = 8'd40; step();
      expect_hint("R11 tie order", 1, 1, 40); idle();
   endtask

   initial begin
      seg_lo = 32'h1000; seg_hi = 32'hFFFF;
      code_lo = 32'h1000; code_hi = 32'h1FFF;
      idle();
      rst_n = 0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      step();
      t_reset();
      t_null();
      t_readonly();
      t_align();
      t_segment();
      t_tlb();
      t_nest();
      t_ret();
      t_fetch();
      t_div();
      t_oldest();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule